// File: doc/BRIEF.md
# Packed Sample Unpacker

This block sits at the input of a processing core. It takes a stream of 32-bit words and turns each word into one or more signed 16-bit samples, as a 4-bit format code selects. The low three bits of the code give the packed sample width (32, 16, 8, 4 or 1 bit). The top bit marks the stream as complex, where samples arrive as interleaved in-phase and quadrature pairs. The format code and the enable come from the core's control register: the format is the field at bits [11:8], and the enable is bit 0.

Both sides use valid/ready handshakes. The block holds one word at a time and hands out its samples starting from the least significant end. Narrow samples come out left-justified, so every format appears at the same full scale. A one-bit sample becomes a symmetric positive or negative full-scale value. In complex mode each sample carries a tag that says whether it is the I or the Q part of a pair.

Top module: `smpl_unpack`

## Requirements
- R1: Format bits [2:0] select the sample width and the number of samples per word: 0 gives 16 bit (2 samples), 1 gives 8 bit (4), 2 gives 4 bit (8), 3 gives 1 bit (32), 4 gives 32 bit (1), and codes 5, 6 and 7 act as 16 bit. Every accepted word yields exactly that many output samples.
- R2: The samples of a word come out starting with the least significant field: sample k is taken from bits [k*W +: W].
- R3: The 16-bit output maps each width as follows. A 16-bit field passes unchanged. An 8-bit field is placed in bits [15:8] and a 4-bit field in bits [15:12], with zeros below in both cases. A 32-bit sample gives its upper half, bits [31:16].
- R4: A 1-bit sample of value 1 gives 16'h7FFF and a value of 0 gives 16'h8001.
- R5: Format bit 3 set means complex. The tag `out_q` is 0 for I and 1 for Q and alternates with every emitted sample, starting at I after enable. For real data the tag is 0.
- R6: The format code is captured together with each word at acceptance. Later changes to `fmt` do not affect the samples of a word already held.
- R7: `in_ready` is high only while enabled and either no word is held or the last sample of the held word is being taken in that cycle. In 32-bit mode with `out_ready` held high, one word is accepted on every clock.
- R8: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_q` stay unchanged.
- R9: While `en` is low, `in_ready` and `out_valid` are low. Any held word is discarded, and the I/Q tag restarts at I.
- R10: After reset no word is held and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Processing enable (control register bit 0) |
| fmt | input | 4 | Input format code (control register bits [11:8]) |
| in_word | input | 32 | Packed input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the word this cycle |
| out_sample | output | 16 | Signed, left-justified sample |
| out_q | output | 1 | 1 when the sample is the Q part of a complex pair |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample this cycle |

## Verification
The bench sweeps all sixteen format codes under random valid/ready gaps and checks every sample against an arithmetic model.

- Scrambling `fmt` while no word is offered catches a design that reads the live code instead of the captured one.
- A wrong samples-per-word count leaves samples missing or extra, and that shows up as a non-empty or underflowing expected queue.
- Back-to-back 32-bit words expose a design that inserts a bubble between words.
- Dropping `en` in mid-word catches a design that emits the stale word afterwards or keeps the Q phase.
- Stalls check that the sample and tag stay held.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    localparam int WORD_W = 32;
    localparam int SMP_W  = 16;
    localparam int FMT_W  = 4;
    localparam int IDX_W  = $clog2(WORD_W);

    localparam logic [SMP_W-1:0] BIT_POS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] BIT_NEG = {1'b1, {(SMP_W-2){1'b0}}, 1'b1};

    typedef enum logic [2:0] {
        WID_16 = 3'd0,
        WID_8  = 3'd1,
        WID_4  = 3'd2,
        WID_1  = 3'd3,
        WID_32 = 3'd4
    } width_e;

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        logic [FMT_W-1:0]  fmt;
        logic [IDX_W-1:0]  idx;
        logic              qph;
    } unp_state_t;

endpackage

// File: rtl/unpack_fmt_dec.sv
module unpack_fmt_dec
    import unpack_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output width_e           width,
    output logic [IDX_W-1:0] last_idx,
    output logic             cplx
);

    always_comb begin
        cplx = fmt[FMT_W-1];
        case (fmt[2:0])
            3'd1: begin
                width    = WID_8;
                last_idx = IDX_W'(WORD_W / 8 - 1);
            end
            3'd2: begin
                width    = WID_4;
                last_idx = IDX_W'(WORD_W / 4 - 1);
            end
            3'd3: begin
                width    = WID_1;
                last_idx = IDX_W'(WORD_W - 1);
            end
            3'd4: begin
                width    = WID_32;
                last_idx = '0;
            end
            default: begin
                width    = WID_16;
                last_idx = IDX_W'(WORD_W / 16 - 1);
            end
        endcase
    end

endmodule

// File: rtl/unpack_slice.sv
module unpack_slice
    import unpack_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  width_e            width,
    input  logic [IDX_W-1:0]  idx,
    output logic [SMP_W-1:0]  sample
);

    localparam int N16 = WORD_W / 16;
    localparam int N8  = WORD_W / 8;
    localparam int N4  = WORD_W / 4;

    logic [15:0] lane16 [N16];
    logic [7:0]  lane8  [N8];
    logic [3:0]  lane4  [N4];

    for (genvar g = 0; g < N16; g++) begin : g_l16
        assign lane16[g] = word[g*16 +: 16];
    end
    for (genvar g = 0; g < N8; g++) begin : g_l8
        assign lane8[g] = word[g*8 +: 8];
    end
    for (genvar g = 0; g < N4; g++) begin : g_l4
        assign lane4[g] = word[g*4 +: 4];
    end

    always_comb begin
        case (width)
            WID_8:   sample = {lane8[idx[1:0]], 8'h00};
            WID_4:   sample = {lane4[idx[2:0]], 12'h000};
            WID_1:   sample = word[idx] ? BIT_POS : BIT_NEG;
            WID_32:  sample = word[WORD_W-1 -: SMP_W];
            default: sample = lane16[idx[0]];
        endcase
    end

endmodule

// File: rtl/smpl_unpack.sv
module smpl_unpack
    import unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FMT_W-1:0]  fmt,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [SMP_W-1:0]  out_sample,
    output logic              out_q,
    output logic              out_valid,
    input  logic              out_ready
);

    unp_state_t st_d, st_q;

    width_e           held_width;
    logic [IDX_W-1:0] held_last;
    logic             held_cplx;
    logic [FMT_W-1:0] held_fmt;
    logic             last_smp;
    logic             take_out;
    logic             take_in;

    assign held_fmt = st_q.fmt;

    unpack_fmt_dec u_dec (
        .fmt      (st_q.fmt),
        .width    (held_width),
        .last_idx (held_last),
        .cplx     (held_cplx)
    );

    unpack_slice u_slice (
        .word   (st_q.word),
        .width  (held_width),
        .idx    (st_q.idx),
        .sample (out_sample)
    );

    assign last_smp  = (st_q.idx == held_last);
    assign out_valid = en && st_q.full;
    assign out_q     = held_cplx && st_q.qph;
    assign take_out  = out_valid && out_ready;
    assign in_ready  = en && (!st_q.full || (take_out && last_smp));
    assign take_in   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.full = 1'b0;
            st_d.idx  = '0;
            st_d.qph  = 1'b0;
        end else begin
            if (take_out) begin
                st_d.qph = held_cplx ? !st_q.qph : 1'b0;
                if (last_smp) begin
                    st_d.full = 1'b0;
                    st_d.idx  = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            if (take_in) begin
                st_d.full = 1'b1;
                st_d.word = in_word;
                st_d.fmt  = fmt;
                st_d.idx  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/unpack_chk.sv
module unpack_chk
    import unpack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              in_valid,
    input logic              in_ready,
    input logic [SMP_W-1:0]  out_sample,
    input logic              out_q,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FMT_W-1:0]  held_fmt
);

    logic exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            exp_q <= 1'b0;
        end else if (out_valid && out_ready) begin
            exp_q <= held_fmt[FMT_W-1] ? !exp_q : 1'b0;
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!out_valid && !in_ready)); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!en || ($stable(out_sample) && $stable(out_q) && out_valid))); // R8

    AST_ACCEPT_ONLY_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && out_valid) |-> out_ready); // R7

    AST_REAL_TAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !held_fmt[FMT_W-1]) |-> !out_q); // R5

    AST_IQ_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && held_fmt[FMT_W-1]) |-> (out_q == exp_q)); // R5

    AST_ONE_BIT_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && held_fmt[2:0] == 3'd3) |-> (out_sample == BIT_POS || out_sample == BIT_NEG)); // R4

    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> en); // R10

endmodule

bind smpl_unpack unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_sample (out_sample),
    .out_q      (out_q),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .held_fmt   (held_fmt)
);

// File: tb/smpl_unpack_test.sv
`timescale 1ns/1ps
module smpl_unpack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  fmt = 4'd0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_sample;
    logic        out_q;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [16:0] expq [$];
    logic        tag_b = 1'b0;
    logic [31:0] rng = 32'h1234_5678;
    bit          acc;
    bit          prev_stall = 0;
    logic [15:0] prev_smp;
    logic        prev_q;

    smpl_unpack uut (
        .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .out_sample(out_sample), .out_q(out_q), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic int nsamp(input logic [3:0] f);
        case (f[2:0])
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 32;
            3'd4: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [31:0] w, input logic [3:0] f, input int k);
        case (f[2:0])
            3'd1: return {w[k*8 +: 8], 8'h00};
            3'd2: return {w[k*4 +: 4], 12'h000};
            3'd3: return w[k] ? 16'h7FFF : 16'h8001;
            3'd4: return w[31:16];
            default: return w[k*16 +: 16];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Evaluate the handshakes that the coming clock edge will commit, then wait for the next falling edge.
    task automatic step();
        logic [16:0] e;
        #1;
        acc = 0;
        if (!en) begin
            expq.delete();
            tag_b = 1'b0;
        end
        if (prev_stall && en) begin
            check(out_valid && out_sample == prev_smp && out_q == prev_q, "R8 stall hold",
                  {15'd0, out_q, out_sample}, {15'd0, prev_q, prev_smp});
        end
        prev_stall = en && out_valid && !out_ready;
        prev_smp   = out_sample;
        prev_q     = out_q;
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(0, "R1 extra sample", {16'd0, out_sample}, 32'd0);
            end else begin
                e = expq.pop_front();
                check(out_sample == e[15:0], "R2 R3 R4 sample value", {16'd0, out_sample}, {16'd0, e[15:0]});
                check(out_q == e[16], "R5 iq tag", {31'd0, out_q}, {31'd0, e[16]});
            end
        end
        if (in_valid && in_ready) begin
            acc = 1;
            for (int k = 0; k < nsamp(fmt); k++) begin
                expq.push_back({fmt[3] ? tag_b : 1'b0, model(in_word, fmt, k)});
                tag_b = fmt[3] ? !tag_b : 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_fmt(input logic [3:0] f, input int nw);
        int left = nw;
        int cyc = 0;
        while ((left > 0 || expq.size() != 0) && cyc < 3000) begin
            rng = nxt(rng);
            in_valid  = (left > 0) && rng[0];
            in_word   = nxt(rng ^ 32'h9E37_79B9);
            // R6: the format input is scrambled whenever no word is offered
            fmt       = in_valid ? f : rng[7:4];
            out_ready = rng[2] | rng[3];
            step();
            if (acc) left--;
            cyc++;
        end
        in_valid  = 0;
        out_ready = 0;
        check(expq.size() == 0 && left == 0, "R1 sample count per word", expq.size(), 0);
        step();
        check(!out_valid, "R1 no leftover sample", {31'd0, out_valid}, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        en = 1;
        #1;
        check(!out_valid, "R10 reset valid", {31'd0, out_valid}, 0);
        check(in_ready, "R10 ready after reset", {31'd0, in_ready}, 1);
        @(negedge clk);

        for (int f = 0; f < 16; f++) begin
            run_fmt(4'(f), (f[2:0] == 3'd3) ? 3 : 6);
        end

        // R7: back-to-back 32-bit words at full rate
        fmt = 4'd4;
        out_ready = 1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            in_valid = 1;
            in_word = 32'hA000_0000 + 32'(i) * 32'h0001_0001;
            step();
            if (acc) n++;
        end
        in_valid = 0;
        step();
        check(n == 8, "R7 one word per clock", n, 8);

        // R9: enable drop in mid-word discards the word and restarts the tag
        fmt = 4'd9;
        in_word = 32'h4433_2211;
        in_valid = 1;
        out_ready = 0;
        step();
        in_valid = 0;
        out_ready = 1;
        step();
        out_ready = 0;
        en = 0;
        in_valid = 1;
        #1;
        check(!out_valid && !in_ready, "R9 idle while disabled", {30'd0, out_valid, in_ready}, 0);
        step();
        step();
        en = 1;
        in_valid = 1;
        in_word = 32'h0000_AA55;
        step();
        in_valid = 0;
        out_ready = 1;
        #1;
        check(out_valid && out_sample == 16'h5500 && !out_q, "R9 fresh word and I tag after re-enable",
              {15'd0, out_q, out_sample}, 32'h0000_5500);
        @(negedge clk);
        prev_stall = 0;
        expq.pop_front();
        tag_b = 1'b1;
        for (int i = 0; i < 6; i++) step();
        check(expq.size() == 0, "R1 drained after re-enable", expq.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule